// File: doc/BRIEF.md
# Parallel LCD Bus Byte-Swapping Bridge

This block connects a processor's simple register port to an 8-bit parallel LCD controller bus. Software reaches two panel-facing registers: an index register, which puts a byte on the bus with register-select low, and a data register, which does the same with register-select high. A wide data write is broken into a timed train of single-byte bus cycles. Within each byte pair the higher lane goes out first, so a 16-bit pixel written as one word reaches the panel most significant byte first. Reads perform one bus cycle and return the captured byte in every byte lane of the read data.

A third register, the touch control byte, lets software take over four shared pins: register-select, chip-select and data bits 0 and 1. Each pin can be forced low or high, or handed back to the bus function. A resistive touch panel can then be biased through the same connector. Analog conversion and the panel's command set are handled elsewhere.

Top module: `lcd_byte_bridge`

## Requirements
- R1: During reset and in the first idle cycle after it, host_ready=1, lcd_cs_n=1, lcd_wr_n=1, lcd_rd_n=1 and lcd_d_oe=0. lcd_rst_n is 0 while rst_n is low and 1 from the first clock edge after reset is released.
- R2: host_addr[4]=0 selects a panel register, and host_addr[3] picks which one: 0 is the index register, 1 is the data register. During every bus cycle lcd_rs equals host_addr[3]. An index write issues exactly one byte cycle carrying lane 0 (host_wdata[7:0]), whatever host_size is.
- R3: host_size encodes the access width: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes, 3 is 8 bytes. A data write of 2, 4 or 8 bytes issues one byte cycle per byte. Cycle i carries lane i XOR 1, where lane k is host_wdata[8k+7:8k]. The resulting order is 1,0 / 1,0,3,2 / 1,0,3,2,5,4,7,6.
- R4: A 1-byte data write issues exactly one byte cycle carrying lane 0.
- R5: In each byte cycle, lcd_cs_n and the active strobe (lcd_wr_n for writes, lcd_rd_n for reads) stay low for exactly STROBE_CYC clocks. lcd_cs_n then stays high for at least GAP_CYC clocks before the next cycle. For writes, lcd_d_oe is all ones and lcd_d_o is stable throughout the strobe.
- R6: host_ready goes low in the cycle after a panel access is accepted and returns high after the last byte cycle's recovery gap ends. A strobe given while host_ready=0 is ignored: it starts no bus cycle and does not write the touch register.
- R7: A read of either panel register issues exactly one read cycle. After the read, host_rdata holds the byte on lcd_d_i at the end of the strobe, replicated in all eight lanes. Offsets 1 to 7 read the same as offset 0.
- R8: host_addr[4]=1 selects the touch control byte. It is written from host_wdata[7:0] and read back replicated in all eight lanes, with no bus cycle. Fields: [1:0] register-select, [3:2] data bit 0, [5:4] data bit 1, [7:6] chip-select. A field value of 00 drives its pin low and 01 drives it high, with the pin's output enable set.
- R9: A field with bit 1 set (1x, the reset value 8'hFF) releases the pin to the bus function. Data bits 0 and 1 are then tri-stated (oe=0) outside write strobes, and register-select and chip-select follow the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_addr | input | 5 | Register offset: bit 4 touch byte, bit 3 data/index, bits 2:0 ignored |
| host_size | input | 2 | Access width code (0:1, 1:2, 2:4, 3:8 bytes) |
| host_wr | input | 1 | Write strobe, taken when host_ready=1 |
| host_rd | input | 1 | Read strobe, taken when host_ready=1 |
| host_wdata | input | 64 | Write data, lane 0 in bits 7:0 |
| host_rdata | output | 64 | Read data, byte replicated in all lanes |
| host_ready | output | 1 | High when idle and able to accept an access |
| lcd_d_o | output | 8 | Data bus output value |
| lcd_d_oe | output | 8 | Per-bit output enable for the data bus |
| lcd_d_i | input | 8 | Data bus input value |
| lcd_cs_n | output | 1 | Chip-select pin value, active low |
| lcd_cs_oe | output | 1 | Chip-select output enable |
| lcd_rs | output | 1 | Register-select pin value |
| lcd_rs_oe | output | 1 | Register-select output enable |
| lcd_wr_n | output | 1 | Write strobe, active low |
| lcd_rd_n | output | 1 | Read strobe, active low |
| lcd_rst_n | output | 1 | Panel reset, active low |

## Verification
The assertions check three rules on every cycle: the strobe width and recovery gap of each bus cycle, data stability under the write strobe, and that host_ready is never high while a cycle is in flight. They also check that a touch-register write attempted while busy leaves the register unchanged. Only the bench's scenarios can show that the swapped byte order is right for each access width, that index accesses collapse to one cycle, and that reads replicate the sampled byte. The same holds for the pin levels the touch fields force and for the fact that no extra bus cycle follows a strobe issued while busy.

// File: rtl/lcdb_pkg.sv
// Shared types and helpers for the LCD byte bridge.
// Assumes host size codes 0..3 mean 1, 2, 4 and 8 bytes.
package lcdb_pkg;

    typedef enum logic [1:0] {
        SEQ_IDLE   = 2'd0,
        SEQ_STROBE = 2'd1,
        SEQ_GAP    = 2'd2
    } seq_state_t;

    // Index of the last beat of an access (beats counted from 0).
    function automatic logic [2:0] last_beat(input logic single, input logic [1:0] size);
        logic [3:0] n;
        n = 4'd1 << size;
        return single ? 3'd0 : 3'(n - 4'd1);
    endfunction

endpackage

// File: rtl/lcdb_seq.sv
// Byte-cycle sequencer: turns one accepted access into a train of
// single-byte bus cycles. Each has a strobe phase (CS and WR/RD low)
// followed by a recovery gap. Multi-byte writes send lanes in pair-swapped order.
// Assumes STROBE_CYC >= 1 and GAP_CYC >= 1.
module lcdb_seq
    import lcdb_pkg::*;
#(
    parameter int STROBE_CYC = 3,
    parameter int GAP_CYC    = 2,
    parameter int DW         = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          start_rd,
    input  logic          start_rs,
    input  logic [1:0]    start_size,
    input  logic [DW-1:0] start_data,
    input  logic [7:0]    bus_d_i,
    output logic          busy,
    output logic          bus_cs_n,
    output logic          bus_wr_n,
    output logic          bus_rd_n,
    output logic          bus_rs,
    output logic [7:0]    bus_d_o,
    output logic          bus_d_oe,
    output logic [7:0]    rd_byte,
    output logic          rd_valid
);
    localparam int MAXC = (STROBE_CYC > GAP_CYC) ? STROBE_CYC : GAP_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    seq_state_t    state;
    logic [CW-1:0] tcnt;
    logic [2:0]    beat, beat_last;
    logic          is_rd, swap;
    logic [DW-1:0] data_q;
    logic [2:0]    lane;

    // Phase, beat and timing counter state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SEQ_IDLE;
            tcnt      <= '0;
            beat      <= '0;
            beat_last <= '0;
            is_rd     <= 1'b0;
            swap      <= 1'b0;
            bus_rs    <= 1'b0;
            data_q    <= '0;
            rd_byte   <= '0;
            rd_valid  <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            case (state)
                SEQ_IDLE: if (start) begin
                    state     <= SEQ_STROBE;
                    tcnt      <= '0;
                    beat      <= '0;
                    beat_last <= last_beat(start_rd || !start_rs, start_size);
                    swap      <= !(start_rd || !start_rs) && (start_size != 2'd0);
                    is_rd     <= start_rd;
                    bus_rs    <= start_rs;
                    data_q    <= start_data;
                end
                SEQ_STROBE: if (tcnt == CW'(STROBE_CYC - 1)) begin
                    tcnt  <= '0;
                    state <= SEQ_GAP;
                    if (is_rd) begin
                        rd_byte  <= bus_d_i;
                        rd_valid <= 1'b1;
                    end
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
                SEQ_GAP: if (tcnt == CW'(GAP_CYC - 1)) begin
                    tcnt <= '0;
                    if (beat == beat_last) begin
                        state <= SEQ_IDLE;
                    end else begin
                        beat  <= beat + 1'b1;
                        state <= SEQ_STROBE;
                    end
                end else begin
                    tcnt <= tcnt + 1'b1;
                end
                default: state <= SEQ_IDLE;
            endcase
        end
    end

    // Lane select: pair-swapped for multi-byte data writes.
    always_comb lane = swap ? (beat ^ 3'd1) : beat;

    // Bus pin values derived from the phase.
    always_comb begin
        busy     = (state != SEQ_IDLE);
        bus_cs_n = (state != SEQ_STROBE);
        bus_wr_n = !((state == SEQ_STROBE) && !is_rd);
        bus_rd_n = !((state == SEQ_STROBE) && is_rd);
        bus_d_oe = (state == SEQ_STROBE) && !is_rd;
        bus_d_o  = data_q[lane*8 +: 8];
    end

    // Checker counters: consecutive low and high cycles of chip-select.
    logic [CW:0] lo_cnt, hi_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_cnt <= '0;
            hi_cnt <= (CW+1)'(GAP_CYC);
        end else begin
            lo_cnt <= bus_cs_n ? '0 : lo_cnt + 1'b1;
            if (!bus_cs_n)                         hi_cnt <= '0;
            else if (hi_cnt < (CW+1)'(GAP_CYC))    hi_cnt <= hi_cnt + 1'b1;
        end
    end

    // R5: strobe lasts exactly STROBE_CYC clocks.
    assert_strobe_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_cs_n) |-> lo_cnt == (CW+1)'(STROBE_CYC));
    // R5: recovery gap of at least GAP_CYC clocks before each strobe.
    assert_gap_width_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_cs_n) |-> hi_cnt >= (CW+1)'(GAP_CYC));
    // R5: write data stable while the write strobe stays low.
    assert_data_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_wr_n && $past(!bus_wr_n)) |-> $stable(bus_d_o));

endmodule

// File: rtl/lcdb_touch.sv
// Touch pin override: four 2-bit fields force register-select, data
// bits 0 and 1 and chip-select low (00) or high (01), or release
// them (1x) to the bus function. Other data bits pass straight through.
module lcdb_touch (
    input  logic [7:0] ctl,
    input  logic       bus_rs,
    input  logic       bus_cs_n,
    input  logic [7:0] bus_d_o,
    input  logic       bus_d_oe,
    output logic       pin_rs,
    output logic       pin_rs_oe,
    output logic       pin_cs_n,
    output logic       pin_cs_oe,
    output logic [7:0] pin_d_o,
    output logic [7:0] pin_d_oe
);
    localparam int NPIN = 4;
    logic [NPIN-1:0] b_o, b_oe, p_o, p_oe;

    // Bus-side values of the shared pins, field order rs, d0, d1, cs.
    always_comb begin
        b_o  = {bus_cs_n, bus_d_o[1], bus_d_o[0], bus_rs};
        b_oe = {1'b1, bus_d_oe, bus_d_oe, 1'b1};
    end

    for (genvar g = 0; g < NPIN; g++) begin : g_pin
        // Override or pass one shared pin.
        always_comb begin
            p_o[g]  = ctl[2*g+1] ? b_o[g]  : ctl[2*g];
            p_oe[g] = ctl[2*g+1] ? b_oe[g] : 1'b1;
        end
    end

    // Reassemble pin-level outputs.
    always_comb begin
        pin_rs    = p_o[0];
        pin_rs_oe = p_oe[0];
        pin_cs_n  = p_o[3];
        pin_cs_oe = p_oe[3];
        pin_d_o   = {bus_d_o[7:2], p_o[2], p_o[1]};
        pin_d_oe  = {{6{bus_d_oe}}, p_oe[2], p_oe[1]};
    end

endmodule

// File: rtl/lcd_byte_bridge.sv
// Top: host register decode, touch control byte, read-data register
// and panel reset. Assumes one strobe at a time, taken only while
// host_ready is high; host_addr[2:0] does not change behaviour.
module lcd_byte_bridge #(
    parameter int STROBE_CYC = 3,
    parameter int GAP_CYC    = 2,
    parameter int AW         = 5,
    parameter int DW         = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] host_addr,
    input  logic [1:0]    host_size,
    input  logic          host_wr,
    input  logic          host_rd,
    input  logic [DW-1:0] host_wdata,
    output logic [DW-1:0] host_rdata,
    output logic          host_ready,
    output logic [7:0]    lcd_d_o,
    output logic [7:0]    lcd_d_oe,
    input  logic [7:0]    lcd_d_i,
    output logic          lcd_cs_n,
    output logic          lcd_cs_oe,
    output logic          lcd_rs,
    output logic          lcd_rs_oe,
    output logic          lcd_wr_n,
    output logic          lcd_rd_n,
    output logic          lcd_rst_n
);
    localparam int LANES = DW / 8;

    logic       busy, bus_cs_n, bus_wr_n, bus_rd_n, bus_rs, bus_d_oe, rd_valid;
    logic [7:0] bus_d_o, rd_byte, touch_q;
    logic       sel_touch, take, start;

    // Access decode: accepted only while idle.
    always_comb begin
        sel_touch = host_addr[4];
        take      = !busy && (host_wr || host_rd);
        start     = take && !sel_touch;
    end

    lcdb_seq #(.STROBE_CYC(STROBE_CYC), .GAP_CYC(GAP_CYC), .DW(DW)) i_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .start_rd(host_rd),
        .start_rs(host_addr[3]), .start_size(host_size), .start_data(host_wdata),
        .bus_d_i(lcd_d_i), .busy(busy), .bus_cs_n(bus_cs_n), .bus_wr_n(bus_wr_n),
        .bus_rd_n(bus_rd_n), .bus_rs(bus_rs), .bus_d_o(bus_d_o), .bus_d_oe(bus_d_oe),
        .rd_byte(rd_byte), .rd_valid(rd_valid)
    );

    lcdb_touch i_touch (
        .ctl(touch_q), .bus_rs(bus_rs), .bus_cs_n(bus_cs_n), .bus_d_o(bus_d_o),
        .bus_d_oe(bus_d_oe), .pin_rs(lcd_rs), .pin_rs_oe(lcd_rs_oe),
        .pin_cs_n(lcd_cs_n), .pin_cs_oe(lcd_cs_oe), .pin_d_o(lcd_d_o), .pin_d_oe(lcd_d_oe)
    );

    // Touch control byte, read data and panel reset registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            touch_q    <= 8'hFF;
            host_rdata <= '0;
            lcd_rst_n  <= 1'b0;
        end else begin
            lcd_rst_n <= 1'b1;
            if (take && sel_touch && host_wr) touch_q <= host_wdata[7:0];
            if (take && sel_touch && host_rd) host_rdata <= {LANES{touch_q}};
            else if (rd_valid)                host_rdata <= {LANES{rd_byte}};
        end
    end

    always_comb begin
        host_ready = !busy;
        lcd_wr_n   = bus_wr_n;
        lcd_rd_n   = bus_rd_n;
    end

    // R6: never ready while a bus strobe is in progress.
    assert_ready_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
        host_ready |-> (bus_cs_n && bus_wr_n && bus_rd_n));
    // R6: a touch write offered while busy does not change the register.
    assert_busy_ignore_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_ready && host_wr && sel_touch) |=> $stable(touch_q));

endmodule

// File: tb/test_lcd_byte_bridge.sv
// Scoreboard bench: host tasks queue the expected byte cycles, and a
// monitor pops and compares them as the strobes fall on the pins.
module test_lcd_byte_bridge;
    localparam int CLK_PERIOD = 10;
    localparam int S = 3;
    localparam int G = 2;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [4:0]  host_addr = '0;
    logic [1:0]  host_size = '0;
    logic        host_wr = 1'b0, host_rd = 1'b0;
    logic [63:0] host_wdata = '0, host_rdata;
    logic        host_ready;
    logic [7:0]  lcd_d_o, lcd_d_oe, lcd_d_i = '0;
    logic        lcd_cs_n, lcd_cs_oe, lcd_rs, lcd_rs_oe, lcd_wr_n, lcd_rd_n, lcd_rst_n;

    lcd_byte_bridge #(.STROBE_CYC(S), .GAP_CYC(G)) i_lcd_byte_bridge (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct { bit rd; bit rs; logic [7:0] d; string req; } exp_t;
    exp_t q[$];
    int checks = 0, errors = 0, strobes = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compare each falling strobe with the head of the queue; time widths.
    logic pw = 1'b1, pr = 1'b1, pc = 1'b1;
    int lo = 0, hi = 100;
    always @(negedge clk) begin
        if (rst_n) begin
            if ((pw && !lcd_wr_n) || (pr && !lcd_rd_n)) begin
                strobes++;
                chk(hi >= G, "R5 gap", 64'(hi), 64'(G));
                if (q.size() == 0) begin
                    chk(0, "R6 unexpected byte cycle", 0, 0);
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    chk(lcd_rd_n == !e.rd && lcd_wr_n == e.rd, {e.req, " strobe type"}, 64'(lcd_rd_n), 64'(!e.rd));
                    chk(lcd_rs == e.rs, {e.req, " R2 rs"}, 64'(lcd_rs), 64'(e.rs));
                    chk(!lcd_cs_n, {e.req, " R5 cs low"}, 64'(lcd_cs_n), 0);
                    if (!e.rd) begin
                        chk(lcd_d_o == e.d, {e.req, " byte"}, 64'(lcd_d_o), 64'(e.d));
                        chk(lcd_d_oe == 8'hFF, {e.req, " R5 oe"}, 64'(lcd_d_oe), 64'hFF);
                    end
                end
            end
            if ((!pw && lcd_wr_n) || (!pr && lcd_rd_n))
                chk(lo == S, "R5 strobe width", 64'(lo), 64'(S));
            lo = (!lcd_wr_n || !lcd_rd_n) ? lo + 1 : 0;
            hi = lcd_cs_n ? hi + 1 : 0;
        end
        pw = lcd_wr_n; pr = lcd_rd_n; pc = lcd_cs_n;
    end

    task automatic wait_ready();
        @(negedge clk);
        while (!host_ready) @(negedge clk);
    endtask

    task automatic host_write(input logic [4:0] a, input logic [1:0] sz, input logic [63:0] d, input string req);
        int n;
        wait_ready();
        host_addr = a; host_size = sz; host_wdata = d; host_wr = 1'b1;
        if (!a[4]) begin
            n = (a[3] == 1'b0) ? 1 : (1 << sz);
            for (int i = 0; i < n; i++) begin
                exp_t e;
                int lane;
                lane = (n == 1) ? 0 : (i ^ 1);
                e.rd = 0; e.rs = a[3]; e.d = d[lane*8 +: 8]; e.req = req;
                q.push_back(e);
            end
        end
        @(negedge clk);
        host_wr = 1'b0;
        if (!a[4]) chk(!host_ready, "R6 ready low after accept", 64'(host_ready), 0);
        while (!host_ready) @(negedge clk);
    endtask

    task automatic host_read(input logic [4:0] a, input logic [1:0] sz);
        wait_ready();
        host_addr = a; host_size = sz; host_rd = 1'b1;
        if (!a[4]) begin
            exp_t e;
            e.rd = 1; e.rs = a[3]; e.d = '0; e.req = "R7";
            q.push_back(e);
        end
        @(negedge clk);
        host_rd = 1'b0;
        while (!host_ready) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int s0;
        repeat (3) @(negedge clk);
        // R1: reset state.
        chk(host_ready && lcd_cs_n && lcd_wr_n && lcd_rd_n && lcd_d_oe == 8'h00,
            "R1 reset outputs", {lcd_d_oe, 4'h0, host_ready, lcd_cs_n, lcd_wr_n, lcd_rd_n}, 64'h0F);
        chk(lcd_rst_n == 1'b0, "R1 panel reset held", 64'(lcd_rst_n), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(lcd_rst_n == 1'b1, "R1 panel reset released", 64'(lcd_rst_n), 1);
        chk(host_ready && lcd_cs_n, "R1 idle after reset", 64'(host_ready), 1);

        // R2: index write collapses to one byte of lane 0.
        host_write(5'h00, 2'd3, 64'hDEAD_BEEF_0102_03A5, "R2 index");
        // R4: single byte data write.
        host_write(5'h08, 2'd0, 64'h0000_0000_0000_7E3C, "R4 byte");
        // R3: 2, 4 and 8 byte writes in pair-swapped order.
        host_write(5'h08, 2'd1, 64'h0000_0000_0000_F81F, "R3 half");
        host_write(5'h0C, 2'd2, 64'h0000_0000_4433_2211, "R3 word");
        host_write(5'h08, 2'd3, 64'h8877_6655_4433_2211, "R3 dword");
        host_write(5'h08, 2'd3, 64'h0102_0408_1020_4080, "R3 dword2");

        // R6: strobes offered while busy are ignored.
        s0 = strobes;
        wait_ready();
        host_addr = 5'h08; host_size = 2'd1; host_wdata = 64'hABCD; host_wr = 1'b1;
        begin
            exp_t e;
            e.rd = 0; e.rs = 1; e.d = 8'hAB; e.req = "R6 first"; q.push_back(e);
            e.d = 8'hCD; q.push_back(e);
        end
        @(negedge clk);
        host_addr = 5'h00; host_wdata = 64'h77;
        repeat (2) @(negedge clk);
        host_addr = 5'h10; host_wdata = 64'h00;
        @(negedge clk);
        host_wr = 1'b0;
        while (!host_ready) @(negedge clk);
        repeat (S + G + 2) @(negedge clk);
        chk(strobes - s0 == 2, "R6 busy strobes ignored", 64'(strobes - s0), 2);
        chk(lcd_d_oe[1:0] == 2'b00, "R6 touch write ignored while busy", 64'(lcd_d_oe), 0);

        // R7: reads replicate the byte, offsets alias.
        lcd_d_i = 8'h5C;
        host_read(5'h0B, 2'd3);
        chk(host_rdata == {8{8'h5C}}, "R7 data read offset 3", host_rdata, {8{8'h5C}});
        lcd_d_i = 8'hA7;
        host_read(5'h05, 2'd0);
        chk(host_rdata == {8{8'hA7}}, "R7 index read offset 5", host_rdata, {8{8'hA7}});

        // R8: touch overrides. rs=01 d0=00 d1=01 cs=10 -> 8'h91.
        host_write(5'h10, 2'd0, 64'h91, "R8 touch");
        @(negedge clk);
        chk(lcd_rs && lcd_rs_oe, "R8 rs forced high", {lcd_rs, lcd_rs_oe}, 2'b11);
        chk(lcd_d_o[0] == 1'b0 && lcd_d_oe[0], "R8 d0 forced low", {lcd_d_o[0], lcd_d_oe[0]}, 2'b01);
        chk(lcd_d_o[1] && lcd_d_oe[1], "R8 d1 forced high", {lcd_d_o[1], lcd_d_oe[1]}, 2'b11);
        chk(lcd_cs_n && lcd_cs_oe, "R9 cs released idle high", {lcd_cs_n, lcd_cs_oe}, 2'b11);
        host_read(5'h17, 2'd3);
        @(negedge clk);
        chk(host_rdata == {8{8'h91}}, "R8 touch readback", host_rdata, {8{8'h91}});
        host_write(5'h10, 2'd0, 64'h34, "R8 touch2"); // cs=00 d1=11 d0=01 rs=00
        @(negedge clk);
        chk(!lcd_rs && lcd_rs_oe, "R8 rs forced low", {lcd_rs, lcd_rs_oe}, 2'b01);
        chk(!lcd_cs_n && lcd_cs_oe, "R8 cs forced low", {lcd_cs_n, lcd_cs_oe}, 2'b01);
        chk(lcd_d_o[0] && lcd_d_oe[0], "R8 d0 forced high", {lcd_d_o[0], lcd_d_oe[0]}, 2'b11);
        chk(lcd_d_oe[1] == 1'b0, "R9 d1 released tri-state", 64'(lcd_d_oe[1]), 0);

        // R9: full release returns pins to the bus function.
        host_write(5'h10, 2'd0, 64'hFF, "R9 release");
        @(negedge clk);
        chk(lcd_d_oe == 8'h00 && lcd_cs_n, "R9 idle pins released", {lcd_d_oe, lcd_cs_n}, 9'h001);
        host_write(5'h08, 2'd1, 64'h1234, "R9 bus after release");

        repeat (S + G + 2) @(negedge clk);
        chk(q.size() == 0, "R3 all expected cycles seen", 64'(q.size()), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule